// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a countdown timer that sits next to a processor's local interrupt logic and is programmed through a small 32-bit register port. Software sets up a control word holding an interrupt vector, a mask bit and a repeat bit. It also selects a clock divider and writes a start value. The block then counts the current value down once for every divided clock period. When the count runs out, it raises an interrupt request that carries the programmed vector, unless the request is masked.

In one-shot use the counter stops at zero after a single expiry and waits to be reloaded. In repeat (periodic) use it reloads the start value on every expiry and keeps counting. A raised request stays up until the acknowledge input is pulsed, so short acknowledge pulses and long service times are both tolerated. The read port is combinational: the data for the current offset is on `reg_rdata` in the same cycle.

Top module: `lapic_tmr`

## Requirements
- R1: After reset the control word reads 0x0001_0000 (masked, vector 0, one-shot), the start value, current count and divider read 0, and `irq_req` is low.
- R2: The control word is at offset 0x320. Its vector is bits 7:0, the mask is bit 16 and the repeat (periodic) select is bit 17. All other bits read back as 0.
- R3: The divider is at offset 0x3E0 and is decoded from bits {3,1,0}. Codes 000, 001, 010 and 011 divide by 2, 4, 8 and 16. Codes 100, 101 and 110 divide by 32, 64 and 128. Code 111 divides by 1.
- R4: Only divider bits 3, 1 and 0 are stored. Every other divider bit reads as 0.
- R5: A write to the start value at offset 0x380 loads the current count (read at offset 0x390) in the same clock edge and starts counting. Writes to offset 0x390 have no effect.
- R6: While the count is non-zero it drops by one every D clock cycles, where D is the divide ratio. A start value N written at edge E expires at edge E + N*D.
- R7: In one-shot mode, expiry leaves the count at 0. It stays at 0 and raises nothing more until the start value is written again.
- R8: In repeat mode, expiry reloads the count from the start value, and the next expiry follows N*D cycles later.
- R9: An expiry while the mask bit is set does not raise `irq_req`.
- R10: An unmasked expiry sets `irq_req` and latches the control vector onto `irq_vector`. Both hold, even if the control word is rewritten, until `irq_ack` is sampled high. If an expiry and an acknowledge arrive in the same cycle, the expiry wins.
- R11: Writing 0 to the start value stops the timer with the count at 0.
- R12: A write to the divider or to the start value restarts the prescaler, so the next decrement comes a full D cycles after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte offset used for both the read and the write |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_req | output | 1 | Pending interrupt request |
| irq_vector | output | 8 | Vector latched at the expiry that raised the request |
| irq_ack | input | 1 | Clears the pending request |

## Verification
The bench builds the block with its default parameters: a 12-bit offset and a full 32-bit counter. The read path and the reserved-bit masking are therefore exercised at their real widths. Small start values, from 2 to 5, keep each expiry within a few hundred cycles. This makes all eight divide ratios, periodic reloads and both prescaler restart cases reachable while every cycle is still compared against the reference model.

// File: rtl/lapic_tmr_pkg.sv
package lapic_tmr_pkg;

  localparam int unsigned REG_W     = 32;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned MAX_SHIFT = 7;

  localparam int unsigned OFS_CTRL  = 32'h320;
  localparam int unsigned OFS_START = 32'h380;
  localparam int unsigned OFS_COUNT = 32'h390;
  localparam int unsigned OFS_DIV   = 32'h3E0;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{periodic: 1'b0, masked: 1'b1, vector: '0};

  function automatic ctrl_t ctrl_unpack(logic [REG_W-1:0] w);
    ctrl_t c;
    c.periodic = w[17];
    c.masked   = w[16];
    c.vector   = w[VEC_W-1:0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_pack(ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[17] = c.periodic;
    w[16] = c.masked;
    w[VEC_W-1:0] = c.vector;
    return w;
  endfunction

  // Divider code gathered from bits {3,1,0}
  function automatic logic [2:0] div_code(logic [REG_W-1:0] w);
    return {w[3], w[1:0]};
  endfunction

  function automatic logic [REG_W-1:0] div_pack(logic [2:0] c);
    logic [REG_W-1:0] w;
    w = '0;
    w[3]   = c[2];
    w[1:0] = c[1:0];
    return w;
  endfunction

  // Ratio is 2**shift; the code plus one, wrapping in three bits, is the shift
  function automatic logic [2:0] div_shift(logic [2:0] c);
    return c + 3'd1;
  endfunction

endpackage

// File: rtl/lapic_tmr_regs.sv
module lapic_tmr_regs
  import lapic_tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              we,
  input  logic [CNT_W-1:0]  cur,
  output logic [REG_W-1:0]  rdata,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  start_q,
  output logic [2:0]        div_c,
  output logic              ld_start,
  output logic              wr_div
);

  logic hit_ctrl, hit_start, hit_count, hit_div;

  assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
  assign hit_start = (addr == ADDR_W'(OFS_START));
  assign hit_count = (addr == ADDR_W'(OFS_COUNT));
  assign hit_div   = (addr == ADDR_W'(OFS_DIV));

  assign ld_start = we && hit_start;
  assign wr_div   = we && hit_div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= CTRL_RST;
      start_q <= '0;
      div_c   <= '0;
    end else begin
      if (we && hit_ctrl) ctrl <= ctrl_unpack(wdata);
      if (ld_start) start_q <= wdata[CNT_W-1:0];
      if (wr_div) div_c <= div_code(wdata);
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl)       rdata = ctrl_pack(ctrl);
    else if (hit_start) rdata = REG_W'(start_q);
    else if (hit_count) rdata = REG_W'(cur);
    else if (hit_div)   rdata = div_pack(div_c);
  end

  // R2
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctrl |-> (rdata[31:18] == '0) && (rdata[15:VEC_W] == '0));

  // R4
  div_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_div |-> (rdata[31:4] == '0) && (rdata[2] == 1'b0));

endmodule

// File: rtl/lapic_tmr_presc.sv
module lapic_tmr_presc
  import lapic_tmr_pkg::*;
#(
  parameter int PRE_W = MAX_SHIFT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       restart,
  input  logic [2:0] shift,
  output logic       tick
);

  localparam int FULL_W = PRE_W + 1;

  logic [PRE_W-1:0]  pre;
  logic [FULL_W-1:0] ratio_full;
  logic [PRE_W-1:0]  ratio_m1;

  assign ratio_full = FULL_W'(1) << shift;
  assign ratio_m1   = PRE_W'(ratio_full - FULL_W'(1));

  assign tick = active && !restart && (pre == ratio_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else if (restart || !active || tick) pre <= '0;
    else pre <= pre + PRE_W'(1);
  end

  // R12
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pre == '0);

  // R3
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= ratio_m1);

endmodule

// File: rtl/lapic_tmr_count.sv
module lapic_tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cur,
  output logic             active,
  output logic             expire
);

  assign active = (cur != '0);
  assign expire = tick && !ld && (cur == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= '0;
    else if (ld) cur <= ld_val;
    else if (tick && active) begin
      if (cur == CNT_W'(1)) cur <= periodic ? reload : '0;
      else cur <= cur - CNT_W'(1);
    end
  end

  // R6
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld && (cur > CNT_W'(1)) |=> cur == $past(cur) - CNT_W'(1));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0) && !ld |=> cur == '0);

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire && periodic |=> cur == $past(reload));

endmodule

// File: rtl/lapic_tmr_irq.sv
module lapic_tmr_irq
  import lapic_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  ctrl_t            ctrl,
  input  logic             ack,
  output logic             irq,
  output logic [VEC_W-1:0] vec
);

  logic fire;
  assign fire = expire && !ctrl.masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      vec <= '0;
    end else if (fire) begin
      irq <= 1'b1;
      vec <= ctrl.vector;
    end else if (ack) begin
      irq <= 1'b0;
    end
  end

  // R9
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ctrl.masked && !irq |=> !irq);

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack && !expire |=> irq && $stable(vec));

endmodule

// File: rtl/lapic_tmr.sv
module lapic_tmr
  import lapic_tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  output logic              irq_req,
  output logic [7:0]        irq_vector,
  input  logic              irq_ack
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] cur;
  logic [2:0]       div_c;
  logic             ld_start, wr_div, restart;
  logic             tick, active, expire;

  assign restart = ld_start || wr_div;

  lapic_tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .we(reg_we), .cur(cur), .rdata(reg_rdata), .ctrl(ctrl),
    .start_q(start_q), .div_c(div_c), .ld_start(ld_start), .wr_div(wr_div)
  );

  lapic_tmr_presc #(.PRE_W(MAX_SHIFT)) u_presc (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(restart),
    .shift(div_shift(div_c)), .tick(tick)
  );

  lapic_tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld_start),
    .ld_val(reg_wdata[CNT_W-1:0]), .periodic(ctrl.periodic),
    .reload(start_q), .cur(cur), .active(active), .expire(expire)
  );

  lapic_tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ctrl(ctrl),
    .ack(irq_ack), .irq(irq_req), .vec(irq_vector)
  );

endmodule

// File: tb/lapic_tmr_tb.sv
module lapic_tmr_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h320, A_START = 12'h380,
                          A_COUNT = 12'h390, A_DIV = 12'h3E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        ack = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  vec;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  lapic_tmr u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata),
    .reg_we(we), .reg_rdata(rdata), .irq_req(irq), .irq_vector(vec),
    .irq_ack(ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model
  logic [31:0] m_ctrl, m_start, m_cur, m_div;
  int          m_el;
  bit          m_irq;
  logic [7:0]  m_vec;

  function automatic int ratio_of(logic [31:0] d);
    case (d[3:0])
      4'h0: return 2;   4'h1: return 4;   4'h2: return 8;   4'h3: return 16;
      4'h8: return 32;  4'h9: return 64;  4'hA: return 128; default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    if (a == A_CTRL) return m_ctrl;
    if (a == A_START) return m_start;
    if (a == A_COUNT) return m_cur;
    if (a == A_DIV) return m_div;
    return 32'h0;
  endfunction

  always @(posedge clk) begin : model
    bit fire;
    fire = 0;
    if (!rst_n) begin
      m_ctrl = 32'h0001_0000; m_start = 0; m_cur = 0; m_div = 0;
      m_el = 0; m_irq = 0; m_vec = 0;
    end else begin
      if (we && addr == A_START) begin
        m_start = wdata; m_cur = wdata; m_el = 0;
      end else if (we && addr == A_DIV) begin
        m_el = 0;
      end else if (m_cur != 0) begin
        m_el++;
        if (m_el == ratio_of(m_div)) begin
          m_el = 0;
          if (m_cur == 1) begin
            fire = 1;
            m_cur = m_ctrl[17] ? m_start : 0;
          end else m_cur--;
        end
      end
      if (fire && !m_ctrl[16]) begin m_irq = 1; m_vec = m_ctrl[7:0]; end
      else if (ack) m_irq = 0;
      if (we && addr == A_CTRL) m_ctrl = wdata & 32'h0003_00FF;
      if (we && addr == A_DIV) m_div = wdata & 32'h0000_000B;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("MODEL irq_req", 32'(irq), 32'(m_irq));
      chk("MODEL irq_vector", 32'(vec), 32'(m_vec));
      chk("MODEL reg_rdata", rdata, exp_rd(addr));
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_ack();
    @(posedge clk); #1 ack = 1'b1;
    @(posedge clk); #1 ack = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 5000) begin @(posedge clk); #1; n++; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, d);  chk("R1 ctrl reset", d, 32'h0001_0000);
    rd(A_START, d); chk("R1 start reset", d, 0);
    rd(A_COUNT, d); chk("R1 count reset", d, 0);
    rd(A_DIV, d);   chk("R1 div reset", d, 0);
    chk("R1 irq reset", 32'(irq), 0);

    // R2 control field layout
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R2 ctrl readback", d, 32'h0003_00FF);

    // R4 reserved divider bits
    wr(A_DIV, 32'hFFFF_FFF4);
    rd(A_DIV, d); chk("R4 div reserved", d, 0);
    wr(A_DIV, 32'h0000_000F);
    rd(A_DIV, d); chk("R4 div kept bits", d, 32'hB);

    // R5 current count is read-only
    wr(A_COUNT, 32'h1234);
    rd(A_COUNT, d); chk("R5 count write ignored", d, 0);

    wr(A_CTRL, 32'h0000_0041);
    // R3 / R6 every divider code, one-shot
    for (int c = 0; c < 8; c++) begin
      int ratio;
      ratio = (c == 7) ? 1 : (2 << c);
      wr(A_DIV, 32'(((c & 4) << 1) | (c & 3)));
      wr(A_START, 3);
      rd(A_COUNT, d); chk("R5 load on start write", d, 3);
      wait_irq(n);
      chk("R3 R6 expiry cycle", 32'(n), 32'(3 * ratio));
      chk("R10 vector", 32'(vec), 32'h41);
      pulse_ack();
      chk("R10 ack clears", 32'(irq), 0);
      rd(A_COUNT, d); chk("R7 stopped at zero", d, 0);
      idle(20);
      rd(A_COUNT, d); chk("R7 stays at zero", d, 0);
      chk("R7 no second irq", 32'(irq), 0);
    end

    // R8 periodic reload
    wr(A_CTRL, 32'h0002_0052);
    wr(A_DIV, 0);
    wr(A_START, 4);
    wait_irq(n); chk("R8 first expiry", 32'(n), 8);
    chk("R8 vector", 32'(vec), 32'h52);
    rd(A_COUNT, d); chk("R8 reloaded", d, 4);
    pulse_ack();
    wait_irq(n); chk("R8 second expiry", 32'(n), 6);
    pulse_ack();

    // R9 masked periodic expiries
    wr(A_CTRL, 32'h0003_0052);
    idle(40);
    chk("R9 masked no irq", 32'(irq), 0);

    // R11 zero stops
    wr(A_START, 0);
    rd(A_COUNT, d); chk("R11 count zero", d, 0);
    idle(20);
    rd(A_COUNT, d); chk("R11 stays stopped", d, 0);
    chk("R11 no irq", 32'(irq), 0);

    // R10 pending hold and latched vector
    wr(A_CTRL, 32'h0000_0077);
    wr(A_DIV, 32'hB);
    wr(A_START, 5);
    wait_irq(n); chk("R10 divide by one expiry", 32'(n), 5);
    idle(30);
    chk("R10 still pending", 32'(irq), 1);
    wr(A_CTRL, 32'h0000_0011);
    chk("R10 vector latched", 32'(vec), 32'h77);
    pulse_ack();
    chk("R10 cleared by ack", 32'(irq), 0);

    // R12 divider write restarts prescaler
    wr(A_DIV, 3);
    wr(A_START, 2);
    idle(10);
    wr(A_DIV, 3);
    wait_irq(n); chk("R12 restart on divider write", 32'(n), 32);
    pulse_ack();

    // R12 start write restarts prescaler
    wr(A_START, 2);
    idle(9);
    wr(A_START, 2);
    wait_irq(n); chk("R12 restart on start write", 32'(n), 32);
    pulse_ack();
    idle(2);

    finish_run();
  end

endmodule